// File: doc/BRIEF.md
# Two-Phase Frame FIFO Pointer Tracker

This block keeps the bookkeeping for a circular buffer whose unit is a frame of 32 bytes. The buffer memory and the data path sit elsewhere. The block only tracks positions and hands out frame offsets relative to a fixed base. A producer can claim room ahead of time and publish it later. A consumer can look at published frames and give them back later. For these two-step uses the block holds a reserved and a committed write position, and a peeked and a released read position.

Two kinds of operation are offered:
- Block-granular split operations work on a multiframe of `MF_LEN` frames: reserve then commit on the write side, peek then release on the read side.
- Frame-granular grants give the largest contiguous run that fits. A grant never crosses the wrap point of the buffer.

Two flush operations realign one side to a multiframe boundary. A driver sends one command per cycle on a one-hot command input. The response comes back on the next cycle. The four occupancy counts follow one cycle after that.

Top module: `frame_ptr_fifo`

## Requirements
- R1: After reset, all four positions are zero. The count outputs then read allocated 0, valid 0, unseen 0 and free DEPTH-1, and `rsp_valid` is low.
- R2: With positions wc (committed), wr (reserved), rr (released) and rp (peeked), all taken modulo DEPTH, the counts are computed as follows:
  - allocated = wr-rr
  - valid = wc-rr
  - unseen = wc-rp
  - free = rr-wr-1
  
  The count outputs show the new positions one cycle after the response to the command that moved them.
- R3: Reserve (cmd bit 0) succeeds only if free ≥ MF_LEN. On success it returns offset BASE+wr and frame count MF_LEN, and advances wr by MF_LEN.
- R4: Commit (cmd bit 1) succeeds only if wr-wc ≥ MF_LEN. On success it returns BASE+wc and MF_LEN, and advances wc by MF_LEN.
- R5: Peek (cmd bit 2) succeeds only if unseen ≥ MF_LEN. On success it returns BASE+rp and MF_LEN, and advances rp by MF_LEN.
- R6: Release (cmd bit 3) succeeds only if rp-rr ≥ MF_LEN. On success it returns BASE+rr and MF_LEN, and advances rr by MF_LEN.
- R7: Frame write (cmd bit 4) grants g = min(`req_frames`, free, DEPTH-wc). It returns BASE+wc and g, and sets both wc and wr to wc+g.
- R8: Frame read (cmd bit 5) grants g = min(`req_frames`, unseen, DEPTH-rp). It returns BASE+rp and g, and sets both rr and rp to rp+g.
- R9: Tail flush (cmd bit 6) sets rr and rp to wc rounded down to a multiple of MF_LEN. It returns BASE plus that value with frame count 0.
- R10: Head flush (cmd bit 7) sets wc and wr to rp rounded up to a multiple of MF_LEN, modulo DEPTH. It returns BASE plus that value with frame count 0.
- R11: The following are rejected: a failed condition, a frame grant of zero, and a command with more than one bit set. A rejected command raises `rsp_reject`, returns offset 0 and count 0, and leaves all positions unchanged.
- R12: Any nonzero command raises `rsp_valid` for exactly the next cycle. A zero command produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 8 | One-hot operation select |
| req_frames | input | $clog2(DEPTH)+1 | Requested frame count for frame-granular grants |
| rsp_valid | output | 1 | Response present |
| rsp_reject | output | 1 | Operation refused |
| rsp_ofs | output | OFS_W | Base-relative frame offset of the operation |
| rsp_frames | output | $clog2(DEPTH)+1 | Frames granted or moved |
| cnt_alloc | output | $clog2(DEPTH) | Frames not writable |
| cnt_valid | output | $clog2(DEPTH) | Committed frames not yet released |
| cnt_unseen | output | $clog2(DEPTH) | Committed frames not yet peeked |
| cnt_free | output | $clog2(DEPTH) | Frames available to reserve |

## Verification
The bench builds the block with DEPTH 32, MF_LEN 4 and BASE 64. With these values a reserve loop fills the buffer in seven steps and every wrap of a pointer comes within a few dozen operations. A long pseudo-random walk therefore passes through full, empty, wrapped and misaligned states many times. Frame-granular grants are truncated at the wrap point often, and both flushes land on unaligned positions often, so rounding and the wrap limit are both exercised.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

    localparam int NCMD = 8;

    // command bit positions (bench relies on these)
    localparam int CMD_RESV    = 0;
    localparam int CMD_COMMIT  = 1;
    localparam int CMD_PEEK    = 2;
    localparam int CMD_RELEASE = 3;
    localparam int CMD_WRITE   = 4;
    localparam int CMD_READ    = 5;
    localparam int CMD_FTAIL   = 6;
    localparam int CMD_FHEAD   = 7;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RESV,
        OP_COMMIT,
        OP_PEEK,
        OP_RELEASE,
        OP_WRITE,
        OP_READ,
        OP_FTAIL,
        OP_FHEAD,
        OP_BAD
    } op_e;

endpackage

// File: rtl/tpf_cmd_decode.sv
module tpf_cmd_decode
    import tpf_pkg::*;
(
    input  logic [NCMD-1:0] cmd,
    output op_e             op
);

    int n_set;
    int idx;

    always_comb begin
        n_set = 0;
        idx   = 0;
        for (int i = 0; i < NCMD; i++) begin
            if (cmd[i]) begin
                n_set = n_set + 1;
                idx   = i;
            end
        end
        if (n_set == 0) begin
            op = OP_NONE;
        end else if (n_set > 1) begin
            op = OP_BAD;
        end else begin
            case (idx)
                CMD_RESV:    op = OP_RESV;
                CMD_COMMIT:  op = OP_COMMIT;
                CMD_PEEK:    op = OP_PEEK;
                CMD_RELEASE: op = OP_RELEASE;
                CMD_WRITE:   op = OP_WRITE;
                CMD_READ:    op = OP_READ;
                CMD_FTAIL:   op = OP_FTAIL;
                default:     op = OP_FHEAD;
            endcase
        end
    end

endmodule

// File: rtl/tpf_occupancy.sv
module tpf_occupancy #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] wc,
    input  logic [PW-1:0] wr,
    input  logic [PW-1:0] rr,
    input  logic [PW-1:0] rp,
    output logic [PW-1:0] alloc,
    output logic [PW-1:0] valid,
    output logic [PW-1:0] unseen,
    output logic [PW-1:0] free,
    output logic [PW-1:0] pend_w,
    output logic [PW-1:0] pend_r
);

    localparam int NDIFF    = 6;
    localparam int FREE_IDX = 3;

    logic [NDIFF-1:0][PW-1:0] hi;
    logic [NDIFF-1:0][PW-1:0] lo;
    logic [NDIFF-1:0][PW-1:0] diff;

    assign hi[0] = wr;  assign lo[0] = rr;
    assign hi[1] = wc;  assign lo[1] = rr;
    assign hi[2] = wc;  assign lo[2] = rp;
    assign hi[3] = rr;  assign lo[3] = wr;
    assign hi[4] = wr;  assign lo[4] = wc;
    assign hi[5] = rp;  assign lo[5] = rr;

    // modular distances; the free count keeps one slot in reserve
    for (genvar g = 0; g < NDIFF; g++) begin : g_diff
        localparam logic [PW-1:0] BIAS = (g == FREE_IDX) ? PW'(1) : '0;
        assign diff[g] = hi[g] - lo[g] - BIAS;
    end

    assign alloc  = diff[0];
    assign valid  = diff[1];
    assign unseen = diff[2];
    assign free   = diff[3];
    assign pend_w = diff[4];
    assign pend_r = diff[5];

endmodule

// File: rtl/tpf_grant.sv
module tpf_grant #(
    parameter int PW = 8
) (
    input  logic [PW:0]   req,
    input  logic [PW-1:0] avail,
    input  logic [PW-1:0] ptr,
    output logic [PW:0]   grant
);

    logic [PW:0] room;
    logic [PW:0] avail_x;
    logic [PW:0] lim;

    // frames left before the wrap point, so a grant stays contiguous
    assign room    = {1'b1, {PW{1'b0}}} - {1'b0, ptr};
    assign avail_x = {1'b0, avail};
    assign lim     = (avail_x < room) ? avail_x : room;
    assign grant   = (req < lim) ? req : lim;

endmodule

// File: rtl/frame_ptr_fifo.sv
module frame_ptr_fifo
    import tpf_pkg::*;
#(
    parameter int          DEPTH  = 256,
    parameter int          MF_LEN = 16,
    parameter int          OFS_W  = 10,
    parameter int unsigned BASE   = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 cmd,
    input  logic [$clog2(DEPTH):0]     req_frames,
    output logic                       rsp_valid,
    output logic                       rsp_reject,
    output logic [OFS_W-1:0]           rsp_ofs,
    output logic [$clog2(DEPTH):0]     rsp_frames,
    output logic [$clog2(DEPTH)-1:0]   cnt_alloc,
    output logic [$clog2(DEPTH)-1:0]   cnt_valid,
    output logic [$clog2(DEPTH)-1:0]   cnt_unseen,
    output logic [$clog2(DEPTH)-1:0]   cnt_free
);

    localparam int              PW       = $clog2(DEPTH);
    localparam int              CW       = PW + 1;
    localparam logic [PW-1:0]   MF_P     = PW'(MF_LEN);
    localparam logic [PW-1:0]   LOW_MASK = PW'(MF_LEN - 1);
    localparam logic [PW-1:0]   ALIGN    = ~LOW_MASK;

    typedef struct packed {
        logic [PW-1:0]    wc;
        logic [PW-1:0]    wr;
        logic [PW-1:0]    rr;
        logic [PW-1:0]    rp;
        logic             rsp_valid;
        logic             rsp_reject;
        logic [OFS_W-1:0] ofs;
        logic [CW-1:0]    frames;
        logic [PW-1:0]    c_alloc;
        logic [PW-1:0]    c_valid;
        logic [PW-1:0]    c_unseen;
        logic [PW-1:0]    c_free;
    } st_t;

    st_t state_d, state_q;
    op_e op;

    logic [PW-1:0] occ_alloc, occ_valid, occ_unseen, occ_free;
    logic [PW-1:0] pend_w, pend_r;
    logic [CW-1:0] wgrant, rgrant;
    logic [PW-1:0] tail_pos, head_pos;

    tpf_cmd_decode u_dec (
        .cmd (cmd),
        .op  (op)
    );

    tpf_occupancy #(.PW(PW)) u_occ (
        .wc     (state_q.wc),
        .wr     (state_q.wr),
        .rr     (state_q.rr),
        .rp     (state_q.rp),
        .alloc  (occ_alloc),
        .valid  (occ_valid),
        .unseen (occ_unseen),
        .free   (occ_free),
        .pend_w (pend_w),
        .pend_r (pend_r)
    );

    tpf_grant #(.PW(PW)) u_wgrant (
        .req   (req_frames),
        .avail (occ_free),
        .ptr   (state_q.wc),
        .grant (wgrant)
    );

    tpf_grant #(.PW(PW)) u_rgrant (
        .req   (req_frames),
        .avail (occ_unseen),
        .ptr   (state_q.rp),
        .grant (rgrant)
    );

    assign tail_pos = state_q.wc & ALIGN;
    assign head_pos = (state_q.rp + LOW_MASK) & ALIGN;

    function automatic logic [OFS_W-1:0] loc(input logic [PW-1:0] p);
        return OFS_W'(BASE) + OFS_W'(p);
    endfunction

    always_comb begin
        state_d            = state_q;
        state_d.rsp_valid  = (op != OP_NONE);
        state_d.rsp_reject = 1'b0;
        state_d.ofs        = '0;
        state_d.frames     = '0;
        // counts follow the registered positions, one cycle behind
        state_d.c_alloc    = occ_alloc;
        state_d.c_valid    = occ_valid;
        state_d.c_unseen   = occ_unseen;
        state_d.c_free     = occ_free;

        case (op)
            OP_RESV: begin
                if (occ_free >= MF_P) begin
                    state_d.ofs    = loc(state_q.wr);
                    state_d.frames = CW'(MF_LEN);
                    state_d.wr     = state_q.wr + MF_P;
                end else begin
                    state_d.rsp_reject = 1'b1;
                end
            end
            OP_COMMIT: begin
                if (pend_w >= MF_P) begin
                    state_d.ofs    = loc(state_q.wc);
                    state_d.frames = CW'(MF_LEN);
                    state_d.wc     = state_q.wc + MF_P;
                end else begin
                    state_d.rsp_reject = 1'b1;
                end
            end
            OP_PEEK: begin
                if (occ_unseen >= MF_P) begin
                    state_d.ofs    = loc(state_q.rp);
                    state_d.frames = CW'(MF_LEN);
                    state_d.rp     = state_q.rp + MF_P;
                end else begin
                    state_d.rsp_reject = 1'b1;
                end
            end
            OP_RELEASE: begin
                if (pend_r >= MF_P) begin
                    state_d.ofs    = loc(state_q.rr);
                    state_d.frames = CW'(MF_LEN);
                    state_d.rr     = state_q.rr + MF_P;
                end else begin
                    state_d.rsp_reject = 1'b1;
                end
            end
            OP_WRITE: begin
                if (wgrant != '0) begin
                    state_d.ofs    = loc(state_q.wc);
                    state_d.frames = wgrant;
                    state_d.wc     = state_q.wc + wgrant[PW-1:0];
                    state_d.wr     = state_q.wc + wgrant[PW-1:0];
                end else begin
                    state_d.rsp_reject = 1'b1;
                end
            end
            OP_READ: begin
                if (rgrant != '0) begin
                    state_d.ofs    = loc(state_q.rp);
                    state_d.frames = rgrant;
                    state_d.rp     = state_q.rp + rgrant[PW-1:0];
                    state_d.rr     = state_q.rp + rgrant[PW-1:0];
                end else begin
                    state_d.rsp_reject = 1'b1;
                end
            end
            OP_FTAIL: begin
                state_d.ofs = loc(tail_pos);
                state_d.rr  = tail_pos;
                state_d.rp  = tail_pos;
            end
            OP_FHEAD: begin
                state_d.ofs = loc(head_pos);
                state_d.wc  = head_pos;
                state_d.wr  = head_pos;
            end
            OP_BAD: begin
                state_d.rsp_reject = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q.c_free <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid  = state_q.rsp_valid;
    assign rsp_reject = state_q.rsp_reject;
    assign rsp_ofs    = state_q.ofs;
    assign rsp_frames = state_q.frames;
    assign cnt_alloc  = state_q.c_alloc;
    assign cnt_valid  = state_q.c_valid;
    assign cnt_unseen = state_q.c_unseen;
    assign cnt_free   = state_q.c_free;

    // response timing
    p_rsp_follows_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != '0) |=> rsp_valid);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == '0) |=> !rsp_valid);

    // malformed commands and refusals
    p_bad_cmd_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot0(cmd) |=> rsp_reject);
    p_reject_holds_ptrs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject |-> (state_q.wc == $past(state_q.wc) && state_q.wr == $past(state_q.wr)
                        && state_q.rr == $past(state_q.rr) && state_q.rp == $past(state_q.rp)));

    // ordering invariants between the pointer pairs
    p_commit_behind_reserve_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_alloc >= cnt_valid);
    p_peek_within_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_unseen <= cnt_valid);

    // multiframe reserve moves exactly one block
    p_resv_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 8'h01) |=> (rsp_reject || rsp_frames == CW'(MF_LEN)));

    // head flush leaves the write side on a block boundary
    p_head_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 8'h80) |=> ((state_q.wc & LOW_MASK) == '0 && state_q.wr == state_q.wc));

endmodule

// File: tb/frame_ptr_fifo_bench.sv
module frame_ptr_fifo_bench;

    localparam int CLK_PERIOD = 10;
    localparam int D     = 32;
    localparam int MF    = 4;
    localparam int PW    = 5;
    localparam int CW    = 6;
    localparam int OW    = 8;
    localparam int BASEV = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    cmd = '0;
    logic [CW-1:0] req = '0;
    logic          rsp_valid, rsp_reject;
    logic [OW-1:0] rsp_ofs;
    logic [CW-1:0] rsp_frames;
    logic [PW-1:0] cnt_alloc, cnt_valid, cnt_unseen, cnt_free;

    frame_ptr_fifo #(.DEPTH(D), .MF_LEN(MF), .OFS_W(OW), .BASE(BASEV)) u_frame_ptr_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .req_frames (req),
        .rsp_valid  (rsp_valid),
        .rsp_reject (rsp_reject),
        .rsp_ofs    (rsp_ofs),
        .rsp_frames (rsp_frames),
        .cnt_alloc  (cnt_alloc),
        .cnt_valid  (cnt_valid),
        .cnt_unseen (cnt_unseen),
        .cnt_free   (cnt_free)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int wc = 0, wr = 0, rr = 0, rp = 0;
    int unsigned seed = 32'h1234_5678;
    bit done = 0;

    function automatic int md(int x);
        return ((x % D) + D) % D;
    endfunction

    function automatic int min3(int a, int b, int c);
        int m = a;
        if (b < m) m = b;
        if (c < m) m = c;
        return m;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_counts(string tag);
        chk({tag, " R2 alloc"},  int'(cnt_alloc),  md(wr - rr));
        chk({tag, " R2 valid"},  int'(cnt_valid),  md(wc - rr));
        chk({tag, " R2 unseen"}, int'(cnt_unseen), md(wc - rp));
        chk({tag, " R2 free"},   int'(cnt_free),   md(rr - wr - 1));
    endtask

    task automatic run_op(logic [7:0] c, int rq);
        int er = 0, eo = 0, ef = 0, g, t;
        string tg = "R12";
        if (c != 0 && $countones(c) > 1) begin
            tg = "R11"; er = 1;
        end else if (c[0]) begin
            tg = "R3";
            if (md(rr - wr - 1) >= MF) begin eo = BASEV + wr; ef = MF; wr = md(wr + MF); end
            else er = 1;
        end else if (c[1]) begin
            tg = "R4";
            if (md(wr - wc) >= MF) begin eo = BASEV + wc; ef = MF; wc = md(wc + MF); end
            else er = 1;
        end else if (c[2]) begin
            tg = "R5";
            if (md(wc - rp) >= MF) begin eo = BASEV + rp; ef = MF; rp = md(rp + MF); end
            else er = 1;
        end else if (c[3]) begin
            tg = "R6";
            if (md(rp - rr) >= MF) begin eo = BASEV + rr; ef = MF; rr = md(rr + MF); end
            else er = 1;
        end else if (c[4]) begin
            tg = "R7";
            g = min3(rq, md(rr - wr - 1), D - wc);
            if (g == 0) er = 1;
            else begin eo = BASEV + wc; ef = g; wc = md(wc + g); wr = wc; end
        end else if (c[5]) begin
            tg = "R8";
            g = min3(rq, md(wc - rp), D - rp);
            if (g == 0) er = 1;
            else begin eo = BASEV + rp; ef = g; rp = md(rp + g); rr = rp; end
        end else if (c[6]) begin
            tg = "R9";
            t = wc - (wc % MF);
            rr = t; rp = t; eo = BASEV + t;
        end else if (c[7]) begin
            tg = "R10";
            t = md(((rp + MF - 1) / MF) * MF);
            wc = t; wr = t; eo = BASEV + t;
        end
        @(negedge clk);
        cmd = c;
        req = CW'(rq);
        @(negedge clk);
        cmd = '0;
        chk({tg, " R12 valid"}, int'(rsp_valid), (c != 0) ? 1 : 0);
        if (c != 0) begin
            chk({tg, er ? " R11 reject" : " reject"}, int'(rsp_reject), er);
            chk({tg, " ofs"}, int'(rsp_ofs), eo);
            chk({tg, " frames"}, int'(rsp_frames), ef);
        end
        @(negedge clk);
        chk_counts(tg);
    endtask

    function automatic int unsigned nxt(int unsigned s);
        int unsigned x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", int'(rsp_valid), 0);
        chk_counts("R1");

        // fill by blocks, then drain by blocks
        for (int i = 0; i < 9; i++) run_op(8'h01, 0);
        for (int i = 0; i < 9; i++) run_op(8'h02, 0);
        for (int i = 0; i < 9; i++) run_op(8'h04, 0);
        for (int i = 0; i < 9; i++) run_op(8'h08, 0);
        // frame-granular grants around the wrap
        run_op(8'h10, 40);
        run_op(8'h20, 40);
        run_op(8'h10, 5);
        run_op(8'h20, 3);
        run_op(8'h20, 0);
        // flushes from unaligned positions
        run_op(8'h80, 0);
        run_op(8'h10, 7);
        run_op(8'h40, 0);
        // malformed and idle commands
        run_op(8'h03, 4);
        run_op(8'hC0, 0);
        run_op(8'h00, 0);

        for (int i = 0; i < 1500; i++) begin
            logic [7:0] c;
            seed = nxt(seed);
            sel = int'(seed % 11);
            if (sel < 8) c = 8'(1 << sel);
            else if (sel == 8) c = 8'(1 << (seed % 8)) | 8'(1 << ((seed / 8 + 1) % 8)) | 8'h01;
            else if (sel == 9) c = 8'h10;
            else c = 8'h00;
            if (c == 8'h01) c = 8'h11;
            seed = nxt(seed);
            run_op(c, int'(seed % (D + 1)));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule